// File: doc/BRIEF.md
# DMA Single-Mode Transfer Sequencer

This block is the transfer engine of a four-channel DMA controller. A separate register block owns the programmed base values and the mode settings. This block owns the working copy of each channel's memory pointer and unit counter. It picks one requesting channel by fixed priority and runs a single transfer unit for it. During that unit it acknowledges the peripheral and drives a memory read or write strobe with the address. After the unit it moves the pointer and lowers the counter.

When a counter runs out, the channel is flagged as finished and its pending-request flag is dropped. If the channel is set to auto-restart, its pointer and counter return to their base values at once. Otherwise the channel stays idle until the register block reloads it. Operating modes other than single, and the illegal transfer type, are refused: those channels are never acknowledged.

Each channel has a six-bit mode field. Bits [5:4] hold the operating mode (0 demand, 1 single, 2 block, 3 cascade). Bit 3 selects downward address stepping. Bit 2 selects auto-restart. Bits [1:0] hold the transfer type (0 verify, 1 memory write, 2 memory read, 3 illegal).

Top module: `dma_single_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, every acknowledge, both memory strobes, every pointer, every counter, every finished flag and every pending flag are zero.
- R2: When several channels are eligible in the same cycle, the one with the lowest index is acknowledged first. The next eligible channel follows once the sequencer is idle again.
- R3: A grant raises exactly one acknowledge bit for exactly one cycle, then the sequencer returns to idle. A channel whose request stays high after its grant is not granted again until the request has been seen low.
- R4: A channel whose mode bits [5:4] are not 1 (single), or whose type bits [1:0] are 3, is never acknowledged, and its counter is left unchanged.
- R5: A channel whose mask bit is set is never acknowledged, and its counter is left unchanged.
- R6: While the acknowledge is high, `mem_addr_o` shows the channel's pointer as it was before the unit. Type 1 raises `mem_wr_o`, type 2 raises `mem_rd_o`, and type 0 raises neither.
- R7: After each unit the pointer moves by 1 on an 8-bit channel and by 2 on a 16-bit channel (`WIDE` bit set). It moves down when mode bit 3 is set and up otherwise, wrapping at the address width.
- R8: After each unit the counter drops by one. The pending flag `req_o[c]` is set by any cycle in which `dreq_i[c]` is high. When a counter reaches zero, `tc_o[c]` is set and `req_o[c]` is cleared. A pulse on `tc_clr_i` clears all finished flags.
- R9: When a counter reaches zero with mode bit 2 set, the pointer and counter are reloaded from `base_addr_i` and `base_cnt_i` in the same update.
- R10: A channel whose counter is zero is not serviced.
- R11: A pulse on `load_i[c]` copies the channel's base pointer and base count into its working pointer and counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | NCH*6 | Per-channel mode fields, channel c at [6c+5:6c] |
| mask_i | input | NCH | Per-channel mask, 1 blocks service |
| base_addr_i | input | NCH*AW | Per-channel base pointer |
| base_cnt_i | input | NCH*CW | Per-channel base unit count |
| load_i | input | NCH | Copy base values into working registers |
| tc_clr_i | input | 1 | Clear all finished flags |
| dreq_i | input | NCH | Peripheral transfer requests |
| dack_o | output | NCH | Peripheral acknowledges, one cycle per unit |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory address of the current unit |
| cur_addr_o | output | NCH*AW | Working pointers |
| cur_cnt_o | output | NCH*CW | Working counters |
| tc_o | output | NCH | Finished flags |
| req_o | output | NCH | Pending-request flags |

## Verification
A request raised before clock edge N produces the acknowledge, the strobe and the address in the cycle after edge N. The pointer, counter, finished-flag and reload effects become visible after edge N+1, when the sequencer returns to idle. When two channels compete, the second acknowledge appears after edge N+2. The bench drives inputs and samples outputs on falling edges, with exactly one rising edge between a stimulus and each sample, so every check falls in the cycle where its result is due. Refusal cases hold the request for four cycles, confirm that no acknowledge appeared, and then read back the unchanged counter.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    localparam int MODE_W = 6;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_UNIT = 1'b1
    } seq_state_e;

    localparam logic [1:0] OPM_SINGLE = 2'd1;

    localparam logic [1:0] XT_VERIFY  = 2'd0;
    localparam logic [1:0] XT_MEMWR   = 2'd1;
    localparam logic [1:0] XT_MEMRD   = 2'd2;
    localparam logic [1:0] XT_ILLEGAL = 2'd3;

    typedef struct packed {
        logic [1:0] opm;
        logic       dec;
        logic       reload;
        logic [1:0] xtype;
    } chan_mode_t;

endpackage

// File: rtl/dma_seq_arb.sv
module dma_seq_arb #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] elig_i,
    output logic [NCH-1:0] gnt_oh_o,
    output logic [IW-1:0]  gnt_idx_o,
    output logic           any_o
);
    // Fixed priority: scan from the top so the lowest index wins.
    always_comb begin
        gnt_oh_o  = '0;
        gnt_idx_o = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (elig_i[c]) begin
                gnt_oh_o  = '0;
                gnt_oh_o[c] = 1'b1;
                gnt_idx_o = IW'(c);
            end
        end
        any_o = |elig_i;
    end
endmodule

// File: rtl/dma_seq_step.sv
module dma_seq_step #(
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter bit WIDE = 1'b0,
    localparam logic [AW-1:0] STEP = WIDE ? AW'(2) : AW'(1)
) (
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          dec_i,
    output logic [AW-1:0] addr_o,
    output logic [CW-1:0] cnt_o,
    output logic          last_o
);
    always_comb begin
        addr_o = dec_i ? (addr_i - STEP) : (addr_i + STEP);
        cnt_o  = cnt_i - CW'(1);
        last_o = (cnt_o == '0);
    end
endmodule

// File: rtl/dma_single_seq.sv
module dma_single_seq
    import dma_seq_pkg::*;
#(
    parameter int             NCH  = 4,
    parameter int             AW   = 16,
    parameter int             CW   = 16,
    parameter logic [NCH-1:0] WIDE = 4'b1100,
    localparam int            MW   = MODE_W,
    localparam int            IW   = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH*MW-1:0] mode_i,
    input  logic [NCH-1:0]    mask_i,
    input  logic [NCH*AW-1:0] base_addr_i,
    input  logic [NCH*CW-1:0] base_cnt_i,
    input  logic [NCH-1:0]    load_i,
    input  logic              tc_clr_i,
    input  logic [NCH-1:0]    dreq_i,
    output logic [NCH-1:0]    dack_o,
    output logic              mem_rd_o,
    output logic              mem_wr_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [NCH*AW-1:0] cur_addr_o,
    output logic [NCH*CW-1:0] cur_cnt_o,
    output logic [NCH-1:0]    tc_o,
    output logic [NCH-1:0]    req_o
);

    typedef struct packed {
        seq_state_e                st;
        logic [NCH-1:0]            gnt;
        logic [NCH-1:0]            armed;
        logic [NCH-1:0]            tc;
        logic [NCH-1:0]            pend;
        logic [NCH-1:0][AW-1:0]    addr;
        logic [NCH-1:0][CW-1:0]    cnt;
        logic                      rd;
        logic                      wr;
        logic [AW-1:0]             maddr;
    } seq_regs_t;

    seq_regs_t q, d;

    chan_mode_t             mode   [NCH];
    logic [NCH-1:0]         elig;
    logic [NCH-1:0]         gnt_oh;
    logic [IW-1:0]          gnt_idx;
    logic                   gnt_any;
    logic [NCH-1:0][AW-1:0] addr_nx;
    logic [NCH-1:0][CW-1:0] cnt_nx;
    logic [NCH-1:0]         last_nx;

    // Per-channel mode decode, eligibility and pointer/counter stepping.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign mode[c] = chan_mode_t'(mode_i[c*MW +: MW]);

        assign elig[c] = (q.st == ST_IDLE) && dreq_i[c] && q.armed[c] && !mask_i[c]
                       && (mode[c].opm == OPM_SINGLE) && (mode[c].xtype != XT_ILLEGAL)
                       && (q.cnt[c] != '0);

        dma_seq_step #(
            .AW   (AW),
            .CW   (CW),
            .WIDE (WIDE[c])
        ) step_i (
            .addr_i (q.addr[c]),
            .cnt_i  (q.cnt[c]),
            .dec_i  (mode[c].dec),
            .addr_o (addr_nx[c]),
            .cnt_o  (cnt_nx[c]),
            .last_o (last_nx[c])
        );
    end

    dma_seq_arb #(.NCH(NCH)) arb_i (
        .elig_i    (elig),
        .gnt_oh_o  (gnt_oh),
        .gnt_idx_o (gnt_idx),
        .any_o     (gnt_any)
    );

    always_comb begin
        d = q;

        for (int c = 0; c < NCH; c++) begin
            if (!dreq_i[c]) d.armed[c] = 1'b1;
            if (dreq_i[c])  d.pend[c]  = 1'b1;
            if (tc_clr_i)   d.tc[c]    = 1'b0;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (gnt_any) begin
                    d.st    = ST_UNIT;
                    d.gnt   = gnt_oh;
                    d.armed = d.armed & ~gnt_oh;
                    d.maddr = q.addr[gnt_idx];
                    d.wr    = (mode[gnt_idx].xtype == XT_MEMWR);
                    d.rd    = (mode[gnt_idx].xtype == XT_MEMRD);
                end
            end
            ST_UNIT: begin
                d.st  = ST_IDLE;
                d.gnt = '0;
                d.rd  = 1'b0;
                d.wr  = 1'b0;
                for (int c = 0; c < NCH; c++) begin
                    if (q.gnt[c]) begin
                        d.addr[c] = addr_nx[c];
                        d.cnt[c]  = cnt_nx[c];
                        if (last_nx[c]) begin
                            d.tc[c]   = 1'b1;
                            d.pend[c] = 1'b0;
                            if (mode[c].reload) begin
                                d.addr[c] = base_addr_i[c*AW +: AW];
                                d.cnt[c]  = base_cnt_i[c*CW +: CW];
                            end
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        // A reprogram from the register block overrides any update.
        for (int c = 0; c < NCH; c++) begin
            if (load_i[c]) begin
                d.addr[c] = base_addr_i[c*AW +: AW];
                d.cnt[c]  = base_cnt_i[c*CW +: CW];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= ST_IDLE;
            q.armed <= '1;
        end else begin
            q <= d;
        end
    end

    assign dack_o     = q.gnt;
    assign mem_rd_o   = q.rd;
    assign mem_wr_o   = q.wr;
    assign mem_addr_o = q.maddr;
    assign cur_addr_o = q.addr;
    assign cur_cnt_o  = q.cnt;
    assign tc_o       = q.tc;
    assign req_o      = q.pend;

endmodule

// File: rtl/dma_seq_chk.sv
module dma_seq_chk
    import dma_seq_pkg::*;
#(
    parameter int  NCH = 4,
    localparam int MW  = MODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NCH*MW-1:0] mode_i,
    input logic [NCH-1:0]    mask_i,
    input logic [NCH-1:0]    dreq_i,
    input logic [NCH-1:0]    dack_o,
    input logic              mem_rd_o,
    input logic              mem_wr_o
);
    logic [NCH-1:0] mode_ok;
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            mode_ok[c] = (mode_i[c*MW+4 +: 2] == OPM_SINGLE)
                      && (mode_i[c*MW +: 2] != XT_ILLEGAL);
        end
    end

    // R3: at most one channel acknowledged
    p_ack_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dack_o));

    // R3: an acknowledge lasts one cycle and is followed by an idle cycle
    p_ack_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack_o) |=> (dack_o == '0));

    // R3: acknowledge only for a channel that was requesting
    p_ack_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack_o) |-> ((dack_o & ~$past(dreq_i)) == '0));

    // R4: refused modes and illegal type never acknowledged
    p_single_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack_o) |-> ((dack_o & ~$past(mode_ok)) == '0));

    // R5: masked channels never acknowledged
    p_no_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|dack_o) |-> ((dack_o & $past(mask_i)) == '0));

    // R6: strobes exclusive and only inside an acknowledge
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    p_strobe_in_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o || mem_wr_o) |-> (|dack_o));

endmodule

bind dma_single_seq dma_seq_chk #(.NCH(NCH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .mask_i   (mask_i),
    .dreq_i   (dreq_i),
    .dack_o   (dack_o),
    .mem_rd_o (mem_rd_o),
    .mem_wr_o (mem_wr_o)
);

// File: tb/dma_single_seq_tb.sv
module dma_single_seq_tb_top;
    localparam int NCH = 4;
    localparam int AW  = 16;
    localparam int CW  = 16;
    localparam int MW  = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [NCH*MW-1:0] mode;
    logic [NCH-1:0]    mask;
    logic [NCH*AW-1:0] base_addr;
    logic [NCH*CW-1:0] base_cnt;
    logic [NCH-1:0]    load;
    logic              tc_clr;
    logic [NCH-1:0]    dreq;
    logic [NCH-1:0]    dack;
    logic              mem_rd, mem_wr;
    logic [AW-1:0]     mem_addr;
    logic [NCH*AW-1:0] cur_addr;
    logic [NCH*CW-1:0] cur_cnt;
    logic [NCH-1:0]    tc, req;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    dma_single_seq #(.NCH(NCH), .AW(AW), .CW(CW), .WIDE(4'b1100)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .mask_i(mask),
        .base_addr_i(base_addr), .base_cnt_i(base_cnt), .load_i(load),
        .tc_clr_i(tc_clr), .dreq_i(dreq), .dack_o(dack), .mem_rd_o(mem_rd),
        .mem_wr_o(mem_wr), .mem_addr_o(mem_addr), .cur_addr_o(cur_addr),
        .cur_cnt_o(cur_cnt), .tc_o(tc), .req_o(req)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic [5:0]  md;
        logic [15:0] a;
        logic [15:0] c;
        logic [15:0] ea;
        logic [15:0] ec;
        logic        rd;
        logic        wr;
    } vec_t;

    localparam vec_t VT [5] = '{
        '{2'd0, 6'h11, 16'h1000, 16'd5, 16'h1001, 16'd4, 1'b0, 1'b1},
        '{2'd1, 6'h1A, 16'h2000, 16'd3, 16'h1FFF, 16'd2, 1'b1, 1'b0},
        '{2'd2, 6'h10, 16'h3000, 16'd2, 16'h3002, 16'd1, 1'b0, 1'b0},
        '{2'd3, 6'h19, 16'h4000, 16'd7, 16'h3FFE, 16'd6, 1'b0, 1'b1},
        '{2'd2, 6'h1E, 16'h0000, 16'd9, 16'hFFFE, 16'd8, 1'b1, 1'b0}
    };

    logic [NCH-1:0] cap_dack;
    logic           cap_rd, cap_wr;
    logic [AW-1:0]  cap_maddr;
    logic [NCH-1:0] cap_req;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] addr_of(input int ch);
        return cur_addr[ch*AW +: AW];
    endfunction

    function automatic logic [CW-1:0] cnt_of(input int ch);
        return cur_cnt[ch*CW +: CW];
    endfunction

    task automatic set_mode(input int ch, input logic [5:0] m);
        mode[ch*MW +: MW] = m;
    endtask

    task automatic do_load(input int ch, input logic [AW-1:0] a, input logic [CW-1:0] c);
        base_addr[ch*AW +: AW] = a;
        base_cnt[ch*CW +: CW]  = c;
        load[ch] = 1'b1;
        @(negedge clk);
        load[ch] = 1'b0;
    endtask

    // One unit: raise request, capture the ack cycle, drop request, settle.
    task automatic run_unit(input int ch);
        dreq[ch] = 1'b1;
        @(negedge clk);
        cap_dack  = dack;
        cap_rd    = mem_rd;
        cap_wr    = mem_wr;
        cap_maddr = mem_addr;
        cap_req   = req;
        dreq[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic no_ack(input int ch, input string rq);
        bit seen = 1'b0;
        dreq[ch] = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (dack != '0) seen = 1'b1;
        end
        dreq[ch] = 1'b0;
        @(negedge clk);
        chk(!seen, rq, {31'd0, seen}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode = '0; mask = '0; base_addr = '0; base_cnt = '0;
        load = '0; tc_clr = 1'b0; dreq = '0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        chk(dack == '0 && !mem_rd && !mem_wr, "R1", {28'd0, dack}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cur_cnt == '0 && cur_addr == '0, "R1", cur_cnt[31:0], 32'd0);
        chk(tc == '0 && req == '0 && dack == '0, "R1", {24'd0, tc, req}, 32'd0);

        // Table walk: R3 R6 R7 R8
        for (int i = 0; i < 5; i++) begin
            set_mode(VT[i].ch, VT[i].md);
            do_load(VT[i].ch, VT[i].a, VT[i].c);
            run_unit(VT[i].ch);
            chk(cap_dack == (4'b1 << VT[i].ch), "R3", {28'd0, cap_dack}, {28'd0, 4'b1 << VT[i].ch});
            chk(cap_rd == VT[i].rd && cap_wr == VT[i].wr, "R6", {30'd0, cap_rd, cap_wr}, {30'd0, VT[i].rd, VT[i].wr});
            chk(cap_maddr == VT[i].a, "R6", {16'd0, cap_maddr}, {16'd0, VT[i].a});
            chk(dack == '0, "R3", {28'd0, dack}, 32'd0);
            chk(addr_of(VT[i].ch) == VT[i].ea, "R7", {16'd0, addr_of(VT[i].ch)}, {16'd0, VT[i].ea});
            chk(cnt_of(VT[i].ch) == VT[i].ec, "R8", {16'd0, cnt_of(VT[i].ch)}, {16'd0, VT[i].ec});
        end

        // R2: fixed priority, lowest index first
        set_mode(1, 6'h11); set_mode(2, 6'h10);
        do_load(1, 16'h0100, 16'd4);
        do_load(2, 16'h0200, 16'd4);
        dreq = 4'b0110;
        @(negedge clk);
        chk(dack == 4'b0010, "R2", {28'd0, dack}, 32'h2);
        dreq[1] = 1'b0;
        @(negedge clk);
        chk(dack == '0, "R2", {28'd0, dack}, 32'd0);
        @(negedge clk);
        chk(dack == 4'b0100, "R2", {28'd0, dack}, 32'h4);
        dreq[2] = 1'b0;
        @(negedge clk);

        // R3: held request is not granted twice
        begin
            bit again = 1'b0;
            set_mode(0, 6'h11);
            do_load(0, 16'h0500, 16'd8);
            dreq[0] = 1'b1;
            @(negedge clk);
            chk(dack == 4'b0001, "R3", {28'd0, dack}, 32'h1);
            repeat (4) begin
                @(negedge clk);
                if (dack != '0) again = 1'b1;
            end
            chk(!again, "R3", {31'd0, again}, 32'd0);
            dreq[0] = 1'b0;
            @(negedge clk);
            run_unit(0);
            chk(cap_dack == 4'b0001, "R3", {28'd0, cap_dack}, 32'h1);
            chk(cnt_of(0) == 16'd6, "R3", {16'd0, cnt_of(0)}, 32'd6);
        end

        // R4: refused modes and illegal type
        do_load(3, 16'h0700, 16'd5);
        set_mode(3, 6'h01); no_ack(3, "R4");
        set_mode(3, 6'h21); no_ack(3, "R4");
        set_mode(3, 6'h31); no_ack(3, "R4");
        set_mode(3, 6'h13); no_ack(3, "R4");
        chk(cnt_of(3) == 16'd5, "R4", {16'd0, cnt_of(3)}, 32'd5);

        // R5: masked channel
        set_mode(3, 6'h11);
        mask = 4'b1000;
        no_ack(3, "R5");
        chk(cnt_of(3) == 16'd5, "R5", {16'd0, cnt_of(3)}, 32'd5);
        mask = '0;
        run_unit(3);
        chk(cap_dack == 4'b1000, "R5", {28'd0, cap_dack}, 32'h8);

        // R8 R9: terminal count with auto-restart
        set_mode(0, 6'h15);
        do_load(0, 16'h0010, 16'd2);
        run_unit(0);
        chk(addr_of(0) == 16'h0011 && cnt_of(0) == 16'd1 && !tc[0], "R8", {addr_of(0), cnt_of(0)}, 32'h0011_0001);
        run_unit(0);
        chk(cap_req[0] == 1'b1, "R8", {31'd0, cap_req[0]}, 32'd1);
        chk(tc[0] == 1'b1 && req[0] == 1'b0, "R8", {30'd0, tc[0], req[0]}, 32'h2);
        chk(addr_of(0) == 16'h0010 && cnt_of(0) == 16'd2, "R9", {addr_of(0), cnt_of(0)}, 32'h0010_0002);
        tc_clr = 1'b1;
        @(negedge clk);
        tc_clr = 1'b0;
        chk(tc[0] == 1'b0, "R8", {31'd0, tc[0]}, 32'd0);

        // R10 R11: terminal count without auto-restart, then reload
        set_mode(1, 6'h11);
        do_load(1, 16'h0050, 16'd1);
        run_unit(1);
        chk(tc[1] == 1'b1 && cnt_of(1) == 16'd0, "R10", {15'd0, tc[1], cnt_of(1)}, 32'h1_0000);
        chk(addr_of(1) == 16'h0051, "R10", {16'd0, addr_of(1)}, 32'h51);
        no_ack(1, "R10");
        do_load(1, 16'h0060, 16'd2);
        chk(addr_of(1) == 16'h0060 && cnt_of(1) == 16'd2, "R11", {addr_of(1), cnt_of(1)}, 32'h0060_0002);
        run_unit(1);
        chk(cap_dack == 4'b0010, "R11", {28'd0, cap_dack}, 32'h2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule